// File: doc/BRIEF.md
# Multiplexed Block-Transfer I/O Channel

This block is a cycle-stealing channel that moves blocks of words between up to sixteen devices and main memory without the processor running any code per word. Each device has its own subchannel. The program sets up a pair of pointers in memory for each subchannel: the current address and the final address. It then starts the subchannel. From then on, each word the device asks for goes through one short sequence of memory cycles on the shared memory port. The channel takes those cycles only when a device is asking, so every other memory cycle stays with the processor.

The channel keeps no address or limit registers of its own. For every word it reads both pointers from a fixed table in memory and writes the advanced current pointer back. When the word at the final address has been moved, the subchannel raises a maskable end-of-range interrupt. It then either stops or, when auto-switching is on, turns to a second pointer pair kept right after the first and carries on into the alternate buffer.

Top module: `mux_block_chan`

## Requirements
- R1: After reset, `mem_req` is low, `irq` is all zero, and no subchannel is active, so device requests receive no acknowledge.
- R2: Each word uses exactly four granted memory cycles, in this order. First, a read of the current pointer at `PTR_BASE + 4*ch + 2*sel`. Second, a read of the final pointer at that address plus one. Third, the data access at the current pointer. Fourth, a write of the current pointer plus one back to the current-pointer location. `dev_ack` pulses during the data cycle.
- R3: The channel never advances a memory cycle without `mem_gnt`. While it waits, it holds `mem_req`, `mem_addr` and `mem_we` steady.
- R4: With `dev_dir` = 1 the device word on `dev_wdata` is written to memory. With `dev_dir` = 0 the memory word is driven on `dev_rdata` in the acknowledge cycle.
- R5: When several active subchannels request together, the lowest-numbered one is served first. At most one `dev_ack` bit is high at a time.
- R6: A request from a subchannel that has not been started causes no memory cycle and no acknowledge.
- R7: After the word at the final address has moved, a subchannel with auto-switch off becomes inactive, and its later requests are ignored.
- R8: End of range sets that subchannel's pending interrupt. `irq` shows pending bits whose `irq_mask` bit is 0, and `irq_clr` clears the pending bit.
- R9: With `auto_sw` set, end of range toggles the subchannel's pointer-pair selector, and the subchannel stays active. Later words then use the pair at offset +2.
- R10: A `start` pulse makes a subchannel active and selects its primary pointer pair (offset +0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | NCH | Start pulse per subchannel |
| auto_sw | input | NCH | Auto-switch enable per subchannel |
| irq_mask | input | NCH | 1 masks that subchannel's interrupt |
| irq_clr | input | NCH | Clears pending interrupt |
| dev_req | input | NCH | Device word request, held until acknowledged |
| dev_dir | input | NCH | 1 = device to memory, 0 = memory to device |
| dev_wdata | input | NCH*DW | Device data, subchannel i at bits i*DW +: DW |
| dev_ack | output | NCH | One-cycle acknowledge of a word |
| dev_rdata | output | DW | Memory data to device, valid with dev_ack |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Grant; a cycle completes on a clock edge with mem_req and mem_gnt high |
| mem_rdata | input | DW | Read data, valid while granted |
| irq | output | NCH | End-of-range interrupts |

## Verification
An idle channel starts a word in the cycle after it sees an active request. The four memory cycles then follow, one per granted edge, and one more idle cycle comes before the next arbitration. So a word with a grant in every cycle takes five cycles. The bench does not predict edge positions, because grants are sometimes withheld. Instead it logs every granted cycle and every acknowledge at the falling clock edge, which is where they are decided. It compares those logs against the expected address order, the word count and the order of service. Pointer values, memory contents and `irq` are checked only once all targets are met and `mem_req` has been low for several cycles. By then the final write-back and the interrupt update, which land on the edge that completes the fourth cycle, have settled.

// File: rtl/mux_block_chan.sv
module mux_block_chan #(
  parameter int NCH      = 16,
  parameter int AW       = 15,
  parameter int DW       = 16,
  parameter int PTR_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    start,
  input  logic [NCH-1:0]    auto_sw,
  input  logic [NCH-1:0]    irq_mask,
  input  logic [NCH-1:0]    irq_clr,
  input  logic [NCH-1:0]    dev_req,
  input  logic [NCH-1:0]    dev_dir,
  input  logic [NCH*DW-1:0] dev_wdata,
  output logic [NCH-1:0]    dev_ack,
  output logic [DW-1:0]     dev_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CUR, S_FIN, S_DATA, S_WBK} st_t;

  st_t            state;
  logic [NCH-1:0] active, sel, pend;
  logic [CW-1:0]  ch, pick;
  logic           pick_ok;
  logic [AW-1:0]  cur, fin, pair;
  logic           fire, last;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (dev_req[i] && active[i]) begin
        pick_ok = 1'b1;
        pick    = CW'(i);
      end
  end

  assign pair    = AW'(PTR_BASE) + AW'({ch, sel[ch], 1'b0});
  assign mem_req = (state != S_IDLE);
  assign fire    = mem_req && mem_gnt;
  assign last    = (cur == fin);
  assign mem_we  = (state == S_WBK) || ((state == S_DATA) && dev_dir[ch]);

  always_comb begin
    case (state)
      S_CUR:   mem_addr = pair;
      S_FIN:   mem_addr = pair + AW'(1);
      S_DATA:  mem_addr = cur;
      default: mem_addr = pair;
    endcase
  end

  assign mem_wdata = (state == S_DATA) ? dev_wdata[ch*DW +: DW] : DW'(cur + AW'(1));
  assign dev_ack   = (state == S_DATA && fire) ? (NCH'(1) << ch) : '0;
  assign dev_rdata = mem_rdata;
  assign irq       = pend & ~irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ch    <= '0;
      cur   <= '0;
      fin   <= '0;
    end else begin
      case (state)
        S_IDLE: if (pick_ok) begin
          ch    <= pick;
          state <= S_CUR;
        end
        S_CUR: if (fire) begin
          cur   <= mem_rdata[AW-1:0];
          state <= S_FIN;
        end
        S_FIN: if (fire) begin
          fin   <= mem_rdata[AW-1:0];
          state <= S_DATA;
        end
        S_DATA: if (fire) state <= S_WBK;
        S_WBK:  if (fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      sel    <= '0;
      pend   <= '0;
    end else begin
      pend <= pend & ~irq_clr;
      if (state == S_WBK && fire && last) begin
        pend[ch] <= 1'b1;
        if (auto_sw[ch]) sel[ch] <= ~sel[ch];
        else             active[ch] <= 1'b0;
      end
      for (int i = 0; i < NCH; i++)
        if (start[i]) begin
          active[i] <= 1'b1;
          sel[i]    <= 1'b0;
        end
    end
  end
endmodule

module mux_block_chan_chk #(
  parameter int NCH = 16,
  parameter int AW  = 15
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dev_ack,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_gnt
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack)); // R5
  AST_ACK_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |-> (mem_req && mem_gnt)); // R2
  AST_WBK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |=> (mem_req && mem_we)); // R2
endmodule

bind mux_block_chan mux_block_chan_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_ack(dev_ack), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt));

// File: tb/mux_block_chan_bench.sv
module mux_block_chan_bench;
  localparam int NCH = 4, AW = 8, DW = 16;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] start = '0, auto_sw = '0, irq_mask = '0, irq_clr = '0;
  logic [NCH-1:0] dev_req, dev_dir = '0, dev_ack, irq, extra = '0;
  logic [NCH*DW-1:0] dev_wdata;
  logic [DW-1:0] dev_rdata, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_gnt = 1'b1;
  logic [AW-1:0] mem_addr;

  logic [15:0] mem [256];
  logic tb_we = 0;
  logic [7:0] tb_a = 0;
  logic [15:0] tb_d = 0;
  logic [7:0] done_cnt [NCH];
  logic [7:0] target [NCH];
  logic stall = 0;
  int cyc = 0, checks = 0, fails = 0;
  int gcount = 0, acount = 0;
  logic [7:0] glog_addr [256];
  logic glog_we [256];
  int ack_ch [64];
  logic [15:0] ack_dat [64];

  always #10 clk = ~clk;

  mux_block_chan #(.NCH(NCH), .AW(AW), .DW(DW), .PTR_BASE(0)) u_mux_block_chan (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_sw(auto_sw), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .dev_req(dev_req), .dev_dir(dev_dir), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .irq(irq));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk)
    for (int i = 0; i < NCH; i++)
      if (!rst_n) done_cnt[i] <= 0;
      else if (dev_ack[i]) done_cnt[i] <= done_cnt[i] + 1;

  always_comb
    for (int i = 0; i < NCH; i++) begin
      dev_req[i] = (done_cnt[i] != target[i]) | extra[i];
      dev_wdata[i*DW +: DW] = 16'hA000 | (16'(i) << 8) | 16'(done_cnt[i]);
    end

  always begin
    @(posedge clk); #2;
    cyc = cyc + 1;
    mem_gnt = stall ? (cyc % 3 == 0) : 1'b1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cyc=%0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (gcount < 256) begin glog_addr[gcount] = mem_addr; glog_we[gcount] = mem_we; end
      gcount = gcount + 1;
    end
    for (int i = 0; i < NCH; i++)
      if (dev_ack[i] && acount < 64) begin
        ack_ch[acount] = i; ack_dat[acount] = dev_rdata; acount = acount + 1;
      end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk); tb_a = 8'(a); tb_d = 16'(d); tb_we = 1;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic pulse_start(input int c);
    @(negedge clk); start[c] = 1;
    @(negedge clk); start[c] = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = 1;
      for (int i = 0; i < NCH; i++) if (done_cnt[i] != target[i]) quiet = 0;
      if (mem_req) quiet = 0;
      if (quiet == 1) begin repeat (3) @(negedge clk); quiet = 4; end
    end
  endtask

  initial begin
    int g0, a0;
    for (int i = 0; i < NCH; i++) target[i] = 0;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    rst_n = 1;
    @(negedge clk);
    extra[2] = 1;
    repeat (10) @(negedge clk);
    chk(dev_ack == 0 && acount == 0, "R1 no ack before start", acount, 0);

    // R6: unstarted subchannel ignored
    extra[3] = 1; g0 = gcount;
    repeat (20) @(negedge clk);
    chk(gcount == g0, "R6 unstarted request ignored", gcount - g0, 0);
    extra[3] = 0; extra[2] = 0;

    // R2 R4 R7 R8: ch1 writes 4 words to 64..67
    poke(4, 64); poke(5, 67);
    dev_dir[1] = 1; g0 = gcount;
    pulse_start(1); target[1] = 4;
    wait_idle();
    chk(gcount - g0 == 16, "R2 four cycles per word", gcount - g0, 16);
    chk(glog_addr[g0] == 4 && !glog_we[g0], "R2 cycle1 read cur ptr", glog_addr[g0], 4);
    chk(glog_addr[g0+1] == 5 && !glog_we[g0+1], "R2 cycle2 read fin ptr", glog_addr[g0+1], 5);
    chk(glog_addr[g0+2] == 64 && glog_we[g0+2], "R2 cycle3 data write", glog_addr[g0+2], 64);
    chk(glog_addr[g0+3] == 4 && glog_we[g0+3], "R2 cycle4 ptr writeback", glog_addr[g0+3], 4);
    for (int k = 0; k < 4; k++)
      chk(mem[64+k] == (16'hA100 | 16'(k)), "R4 device word stored", mem[64+k], 16'hA100 | k);
    chk(mem[4] == 68, "R2 pointer advanced", mem[4], 68);
    chk(irq[1] == 1, "R8 end-of-range irq", irq[1], 1);
    extra[1] = 1; g0 = gcount;
    repeat (20) @(negedge clk);
    chk(gcount == g0, "R7 stopped after final", gcount - g0, 0);
    extra[1] = 0;
    irq_clr[1] = 1; @(negedge clk); irq_clr[1] = 0; @(negedge clk);
    chk(irq[1] == 0, "R8 irq cleared", irq[1], 0);

    // R3 R4 R8: ch0 reads 80..82 with grant stalls, interrupt masked
    for (int k = 0; k < 3; k++) poke(80 + k, 16'h1111 * k + 7);
    poke(0, 80); poke(1, 82);
    irq_mask[0] = 1; stall = 1; dev_dir[0] = 0; a0 = acount;
    pulse_start(0); target[0] = 3;
    wait_idle();
    stall = 0;
    chk(acount - a0 == 3, "R3 all words under stalls", acount - a0, 3);
    for (int k = 0; k < 3; k++)
      chk(ack_dat[a0+k] == 16'(16'h1111 * k + 7), "R4 memory word to device",
          ack_dat[a0+k], 16'h1111 * k + 7);
    chk(mem[0] == 83, "R3 pointer after stalls", mem[0], 83);
    chk(irq[0] == 0, "R8 masked irq low", irq[0], 0);
    irq_mask[0] = 0; @(negedge clk);
    chk(irq[0] == 1, "R8 unmasked irq high", irq[0], 1);
    irq_clr[0] = 1; @(negedge clk); irq_clr[0] = 0;

    // R5: ch0 and ch2 together
    poke(0, 90); poke(1, 92); poke(8, 93); poke(9, 95);
    a0 = acount;
    @(negedge clk); start[0] = 1; start[2] = 1;
    @(negedge clk); start = '0; target[0] = 6; target[2] = 3;
    wait_idle();
    for (int k = 0; k < 6; k++)
      chk(ack_ch[a0+k] == ((k < 3) ? 0 : 2), "R5 lowest first", ack_ch[a0+k], (k < 3) ? 0 : 2);
    irq_clr = '1; @(negedge clk); irq_clr = '0;

    // R9 R10: ch3 auto-switch
    poke(12, 100); poke(13, 101); poke(14, 120); poke(15, 121);
    auto_sw[3] = 1; dev_dir[3] = 1;
    pulse_start(3); target[3] = 3;
    wait_idle();
    chk(mem[100] == 16'hA300 && mem[101] == 16'hA301, "R9 primary block", mem[101], 16'hA301);
    chk(mem[120] == 16'hA302, "R9 switched to alternate", mem[120], 16'hA302);
    chk(mem[14] == 121 && mem[12] == 102, "R9 alternate pointer advanced", mem[14], 121);
    chk(irq[3] == 1, "R8 irq on switch", irq[3], 1);
    irq_clr[3] = 1; @(negedge clk); irq_clr[3] = 0;
    poke(12, 110); poke(13, 110);
    pulse_start(3); target[3] = 4;
    wait_idle();
    chk(mem[110] == 16'hA303, "R10 start selects primary pair", mem[110], 16'hA303);
    chk(mem[121] == 0, "R10 alternate untouched", mem[121], 0);
    chk(irq[3] == 1, "R9 still active after switch, ends again", irq[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule